// File: doc/BRIEF.md
# Interrupt Controller Command Interface

This block is the register front end of an eight-line programmable interrupt controller. A byte-wide bus with one address bit carries configuration and command traffic. Writes at address 0 are sorted by their bit pattern into three kinds: a start-of-initialization word, an end-of-interrupt command, or a read-select command. Writes at address 1 have two possible meanings. They go to the vector base, the cascade configuration or the processor options while an initialization sequence is running. They load the interrupt mask when no sequence is running.

The block holds the interrupt mask, vector base, cascade mask or slave ID, trigger mode, cascade flag, auto end-of-interrupt flag and read-select flag. It sends one-cycle end-of-interrupt strobes with a line number to the request core. It returns the request core's pending register (IRR), the in-service register (ISR) or the mask register (IMR) on reads. Rotation, priority-setting, special-mask and buffering commands are decoded and accepted but change nothing.

Top module: `pic_cmd_if`

## Requirements
- R1: After reset, imr_o is 0, auto_eoi_o is 0, init_busy_o is 0, eoi_o is 0, and an address-0 read returns irr_i.
- R2: A write at address 0 with bit 4 set starts initialization. From the next cycle: imr_o is 0, init_busy_o is 1, edge_trig_o equals bit 3, and cascade_o equals the inverse of bit 1. If bit 0 is 0, auto_eoi_o is 0. Such a write received mid-sequence restarts the sequence at the vector-base step.
- R3: The first address-1 write after a start word sets vec_base_o to bits 7:3 of the data with bits 2:0 forced to 0. If cascade_o is 0, casc_mask_o becomes 0 and init_busy_o falls.
- R4: In cascade mode the next address-1 write is stored in casc_mask_o. With master_i=1 all 8 bits are stored. With master_i=0 only bits 2:0 are stored and the rest are 0. The sequence then ends, unless bit 0 of the start word was 1.
- R5: When requested, a final address-1 write sets auto_eoi_o to its bit 1, ignores its other bits, and ends the sequence.
- R6: An address-1 write with init_busy_o at 0 loads imr_o. An address-1 write that belongs to a sequence leaves imr_o unchanged.
- R7: An address-0 write with bits 4:3 = 00 and bits 7:5 = 001 raises eoi_o for exactly the next cycle. eoi_line_o is the highest-numbered set bit of isr_i at the time of the write. There is no strobe when isr_i is 0.
- R8: An address-0 write with bits 4:3 = 00 and bits 7:5 = 011 raises eoi_o for the next cycle, with eoi_line_o equal to bits 2:0, whatever isr_i holds.
- R9: Any other value of bits 7:5 in such a write produces no strobe and leaves imr_o unchanged.
- R10: An address-0 write with bits 4:3 = 01 and bit 1 set selects what address-0 reads return: IRR if bit 0 is 1, ISR if bit 0 is 0. With bit 1 clear the selection is kept.
- R11: An address-1 read returns imr_o. rdata_o is 0 whenever rd_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 1 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| master_i | input | 1 | 1: master, 0: slave (cascade word meaning) |
| irr_i | input | 8 | Pending requests from the request core |
| isr_i | input | 8 | In-service lines from the request core |
| imr_o | output | 8 | Interrupt mask |
| vec_base_o | output | 8 | Vector base, low three bits zero |
| casc_mask_o | output | 8 | Slave-attached lines (master) or slave ID |
| edge_trig_o | output | 1 | Edge trigger selected |
| cascade_o | output | 1 | Cascade mode selected |
| auto_eoi_o | output | 1 | Automatic end-of-interrupt |
| init_busy_o | output | 1 | Initialization sequence in progress |
| eoi_o | output | 1 | End-of-interrupt strobe |
| eoi_line_o | output | 3 | Line for the strobe |

## Verification
The assertions assume that wr_i is a single-cycle pulse per byte and that wdata_i and addr_i are valid whenever wr_i is high. They also assume that isr_i is stable in the write cycle of an end-of-interrupt command. The bench drives every input on the falling edge and holds it for one full cycle, so a rising edge never sees a changing value. It changes isr_i only together with the write that samples it. Writes are never issued on back-to-back cycles except where a strobe's one-cycle width is under test.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_BASE, SEQ_CASC, SEQ_OPTS} seq_e;
  typedef enum logic [2:0] {
    CMD_NONE, CMD_START, CMD_EOI_NS, CMD_EOI_SP, CMD_RDSEL, CMD_DATA
  } cmd_e;
endpackage

// File: rtl/pic_cmd_decode.sv
module pic_cmd_decode
  import pic_cmd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          wr_i,
  input  logic          addr_i,
  input  logic [DW-1:0] wdata_i,
  output cmd_e          cmd_o
);
  always_comb begin
    cmd_o = CMD_NONE;
    if (wr_i) begin
      if (addr_i) cmd_o = CMD_DATA;
      else if (wdata_i[4]) cmd_o = CMD_START;
      else if (!wdata_i[3]) begin
        // subcommand field 7:5; only the two EOI forms act
        if (wdata_i[7:5] == 3'b001) cmd_o = CMD_EOI_NS;
        else if (wdata_i[7:5] == 3'b011) cmd_o = CMD_EOI_SP;
      end else if (wdata_i[1]) cmd_o = CMD_RDSEL;
    end
  end
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_cmd_pkg::*;
#(
  parameter int DW     = 8,
  parameter int LINE_W = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  cmd_e          cmd_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          master_i,
  output logic [DW-1:0] vec_base_o,
  output logic [DW-1:0] casc_mask_o,
  output logic          edge_trig_o,
  output logic          cascade_o,
  output logic          auto_eoi_o,
  output logic          busy_o
);
  seq_e state_q;
  logic need_opts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= SEQ_IDLE;
      need_opts_q <= 1'b0;
      vec_base_o  <= '0;
      casc_mask_o <= '0;
      edge_trig_o <= 1'b0;
      cascade_o   <= 1'b0;
      auto_eoi_o  <= 1'b0;
    end else if (cmd_i == CMD_START) begin
      edge_trig_o <= wdata_i[3];
      cascade_o   <= ~wdata_i[1];
      need_opts_q <= wdata_i[0];
      if (!wdata_i[0]) auto_eoi_o <= 1'b0;
      state_q     <= SEQ_BASE;
    end else if (cmd_i == CMD_DATA) begin
      unique case (state_q)
        SEQ_BASE: begin
          vec_base_o <= {wdata_i[DW-1:LINE_W], {LINE_W{1'b0}}};
          if (cascade_o) state_q <= SEQ_CASC;
          else begin
            casc_mask_o <= '0;
            state_q     <= SEQ_IDLE;
          end
        end
        SEQ_CASC: begin
          casc_mask_o <= master_i ? wdata_i
                                  : {{(DW-LINE_W){1'b0}}, wdata_i[LINE_W-1:0]};
          state_q     <= need_opts_q ? SEQ_OPTS : SEQ_IDLE;
        end
        SEQ_OPTS: begin
          auto_eoi_o <= wdata_i[1];
          state_q    <= SEQ_IDLE;
        end
        default: ;
      endcase
    end
  end

  assign busy_o = (state_q != SEQ_IDLE);
endmodule

// File: rtl/pic_eoi_gen.sv
module pic_eoi_gen
  import pic_cmd_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int LINE_W    = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  cmd_e                 cmd_i,
  input  logic [LINE_W-1:0]    line_field_i,
  input  logic [NUM_LINES-1:0] isr_i,
  output logic                 eoi_o,
  output logic [LINE_W-1:0]    eoi_line_o
);
  logic [LINE_W-1:0] top_line;
  logic              any_set;

  always_comb begin
    top_line = '0;
    any_set  = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (isr_i[i]) begin
        top_line = LINE_W'(i);
        any_set  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eoi_o      <= 1'b0;
      eoi_line_o <= '0;
    end else begin
      eoi_o <= 1'b0;
      if (cmd_i == CMD_EOI_SP) begin
        eoi_o      <= 1'b1;
        eoi_line_o <= line_field_i;
      end else if (cmd_i == CMD_EOI_NS && any_set) begin
        eoi_o      <= 1'b1;
        eoi_line_o <= top_line;
      end
    end
  end
endmodule

// File: rtl/pic_cmd_if.sv
module pic_cmd_if
  import pic_cmd_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int DW       = NUM_LINES,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              master_i,
  input  logic [DW-1:0]     irr_i,
  input  logic [DW-1:0]     isr_i,
  output logic [DW-1:0]     imr_o,
  output logic [DW-1:0]     vec_base_o,
  output logic [DW-1:0]     casc_mask_o,
  output logic              edge_trig_o,
  output logic              cascade_o,
  output logic              auto_eoi_o,
  output logic              init_busy_o,
  output logic              eoi_o,
  output logic [LINE_W-1:0] eoi_line_o
);
  cmd_e cmd;
  logic sel_irr_q;

  pic_cmd_decode #(.DW(DW)) u_dec (
    .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i), .cmd_o(cmd)
  );

  pic_init_seq #(.DW(DW), .LINE_W(LINE_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(cmd), .wdata_i(wdata_i),
    .master_i(master_i), .vec_base_o(vec_base_o), .casc_mask_o(casc_mask_o),
    .edge_trig_o(edge_trig_o), .cascade_o(cascade_o),
    .auto_eoi_o(auto_eoi_o), .busy_o(init_busy_o)
  );

  pic_eoi_gen #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_eoi (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(cmd),
    .line_field_i(wdata_i[LINE_W-1:0]), .isr_i(isr_i),
    .eoi_o(eoi_o), .eoi_line_o(eoi_line_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      imr_o     <= '0;
      sel_irr_q <= 1'b1;
    end else begin
      if (cmd == CMD_START) imr_o <= '0;
      else if (cmd == CMD_DATA && !init_busy_o) imr_o <= wdata_i;
      if (cmd == CMD_RDSEL) sel_irr_q <= wdata_i[0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) rdata_o = addr_i ? imr_o : (sel_irr_q ? irr_i : isr_i);
  end
endmodule

// File: rtl/pic_cmd_if_chk.sv
module pic_cmd_if_chk #(
  parameter int NUM_LINES = 8,
  localparam int DW       = NUM_LINES,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic              addr_i,
  input logic [DW-1:0]     wdata_i,
  input logic [DW-1:0]     isr_i,
  input logic [DW-1:0]     imr_o,
  input logic              edge_trig_o,
  input logic              init_busy_o,
  input logic              eoi_o,
  input logic [LINE_W-1:0] eoi_line_o
);
  logic eoi_wr, ns_wr, sp_wr;
  assign ns_wr  = wr_i && !addr_i && wdata_i[4:3] == 2'b00 && wdata_i[7:5] == 3'b001;
  assign sp_wr  = wr_i && !addr_i && wdata_i[4:3] == 2'b00 && wdata_i[7:5] == 3'b011;
  assign eoi_wr = ns_wr || sp_wr;

  p_eoi_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_o |-> $past(eoi_wr));
  p_spec_line_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_wr |=> (eoi_o && eoi_line_o == $past(wdata_i[LINE_W-1:0])));
  p_ns_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ns_wr && isr_i == '0) |=> !eoi_o);
  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !addr_i && wdata_i[4]) |=>
      (imr_o == '0 && init_busy_o && edge_trig_o == $past(wdata_i[3])));
  p_imr_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i && !init_busy_o) |=> imr_o == $past(wdata_i));
  p_imr_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i && init_busy_o) |=> $stable(imr_o));
endmodule

bind pic_cmd_if pic_cmd_if_chk #(.NUM_LINES(NUM_LINES)) u_chk (.*);

// File: tb/sim_pic_cmd_if.sv
module sim_pic_cmd_if;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;

  typedef struct packed {
    logic       a;
    logic [7:0] d;
    logic [7:0] isr;
    logic       eoi;
    logic [2:0] line;
    logic [7:0] imr;
    logic       busy;
  } vec_t;

  // fields: addr, data, isr, exp eoi, exp line, exp imr, exp busy
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'hA5, 8'h00, 1'b0, 3'd0, 8'hA5, 1'b0}, // R6 idle mask load
    '{1'b0, 8'h19, 8'h00, 1'b0, 3'd0, 8'h00, 1'b1}, // R2 start, edge, cascade, opts
    '{1'b1, 8'h47, 8'h00, 1'b0, 3'd0, 8'h00, 1'b1}, // R3 base, R6 mask untouched
    '{1'b1, 8'h84, 8'h00, 1'b0, 3'd0, 8'h00, 1'b1}, // R4 master cascade mask
    '{1'b1, 8'h03, 8'h00, 1'b0, 3'd0, 8'h00, 1'b0}, // R5 opts, auto eoi
    '{1'b1, 8'h3C, 8'h00, 1'b0, 3'd0, 8'h3C, 1'b0}, // R6
    '{1'b0, 8'h20, 8'h14, 1'b1, 3'd4, 8'h3C, 1'b0}, // R7 highest in-service
    '{1'b0, 8'h65, 8'h00, 1'b1, 3'd5, 8'h3C, 1'b0}, // R8 specific
    '{1'b0, 8'h20, 8'h00, 1'b0, 3'd0, 8'h3C, 1'b0}, // R7 empty isr
    '{1'b0, 8'h40, 8'hFF, 1'b0, 3'd0, 8'h3C, 1'b0}, // R9 no-op
    '{1'b0, 8'hE3, 8'hFF, 1'b0, 3'd0, 8'h3C, 1'b0}  // R9 priority form
  };

  logic clk = 0, rst_n = 0;
  logic wr = 0, rd = 0, addr = 0, master = 1;
  logic [7:0] wdata = 0, irr = 0, isr = 0;
  logic [7:0] rdata, imr, vbase, cmask;
  logic edge_t, casc, aeoi, busy, eoi;
  logic [2:0] eline;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pic_cmd_if u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .master_i(master), .irr_i(irr),
    .isr_i(isr), .imr_o(imr), .vec_base_o(vbase), .casc_mask_o(cmask),
    .edge_trig_o(edge_t), .cascade_o(casc), .auto_eoi_o(aeoi),
    .init_busy_o(busy), .eoi_o(eoi), .eoi_line_o(eline)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr = 1; addr = a; wdata = d;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic rd_byte(input logic a, output logic [7:0] d);
    @(negedge clk);
    rd = 1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] r;
    irr = 8'h5A;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 imr", imr, 8'h00);
    chk("R1 aeoi", {7'd0, aeoi}, 8'h00);
    chk("R1 busy", {7'd0, busy}, 8'h00);
    chk("R1 eoi", {7'd0, eoi}, 8'h00);
    rst_n = 1;
    rd_byte(1'b0, r);
    chk("R1 read irr", r, 8'h5A);

    for (int i = 0; i < NV; i++) begin
      isr = VECS[i].isr;
      wr_byte(VECS[i].a, VECS[i].d);
      chk($sformatf("R7/R8/R9 eoi v%0d", i), {7'd0, eoi}, {7'd0, VECS[i].eoi});
      if (VECS[i].eoi) chk($sformatf("R7/R8 line v%0d", i), {5'd0, eline}, {5'd0, VECS[i].line});
      chk($sformatf("R6 imr v%0d", i), imr, VECS[i].imr);
      chk($sformatf("R2 busy v%0d", i), {7'd0, busy}, {7'd0, VECS[i].busy});
      if (i == 1) begin
        chk("R2 edge", {7'd0, edge_t}, 8'd1);
        chk("R2 cascade", {7'd0, casc}, 8'd1);
      end
      if (i == 2) chk("R3 vec base", vbase, 8'h40);
      if (i == 3) chk("R4 master mask", cmask, 8'h84);
      if (i == 4) chk("R5 auto eoi", {7'd0, aeoi}, 8'd1);
      if (VECS[i].eoi) begin
        @(negedge clk);
        chk("R7 one-cycle strobe", {7'd0, eoi}, 8'd0);
      end
    end

    // R10 read select
    isr = 8'h3C;
    wr_byte(1'b0, 8'h0A);
    rd_byte(1'b0, r);
    chk("R10 read isr", r, 8'h3C);
    wr_byte(1'b0, 8'h09);
    rd_byte(1'b0, r);
    chk("R10 keep select", r, 8'h3C);
    wr_byte(1'b0, 8'h0B);
    rd_byte(1'b0, r);
    chk("R10 read irr", r, 8'h5A);
    // R11
    rd_byte(1'b1, r);
    chk("R11 read imr", r, 8'h3C);
    #1 chk("R11 idle zero", rdata, 8'h00);

    // R3 single mode, R2 auto eoi cleared
    wr_byte(1'b0, 8'h12);
    chk("R2 no opts clears aeoi", {7'd0, aeoi}, 8'd0);
    chk("R2 single", {7'd0, casc}, 8'd0);
    wr_byte(1'b1, 8'h2F);
    chk("R3 single base", vbase, 8'h28);
    chk("R3 single mask", cmask, 8'h00);
    chk("R3 single done", {7'd0, busy}, 8'd0);

    // R4 slave id, no opts word
    master = 0;
    wr_byte(1'b0, 8'h10);
    wr_byte(1'b1, 8'h08);
    wr_byte(1'b1, 8'hFE);
    chk("R4 slave id", cmask, 8'h06);
    chk("R4 ends without opts", {7'd0, busy}, 8'd0);

    // R2 restart mid-sequence
    master = 1;
    wr_byte(1'b1, 8'h77);
    wr_byte(1'b0, 8'h11);
    wr_byte(1'b1, 8'h50);
    wr_byte(1'b0, 8'h13);
    chk("R2 restart clears imr", imr, 8'h00);
    wr_byte(1'b1, 8'h98);
    chk("R2 restart base", vbase, 8'h98);
    chk("R2 restart done", {7'd0, busy}, 8'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule